// File: doc/BRIEF.md
# Piecewise-Linear HDR Pixel Decompander

This block converts companded sensor pixels back into linear high-dynamic-range values. Each input is a 12-bit compressed code. The block finds the segment of a knee-point curve that holds the code. It then rebuilds the linear value from that segment's base value and from its slope, which is a fixed-point number scaled by a programmable power of two. Results can be up to 20 bits wide. When expansion is turned off, the code passes straight through, widened with zeros.

The curve is loaded through a simple word-wide write port, one word per cycle. All writes go into a staging copy. A small two-state machine tracks whether that copy differs from the working curve:

- In state CFG_SYNCED the staging copy and the working curve match. Any write moves the machine to CFG_STAGED.
- In state CFG_STAGED, a frame-start pulse with no write in the same cycle copies the staging copy into the working curve and returns the machine to CFG_SYNCED.
- A frame-start pulse that arrives together with a write still copies the staging copy as it stood before that write, and the machine stays in CFG_STAGED.

Because of this, the curve never changes partway through a frame. Pixels flow on a valid/ready stream through a fixed two-stage pipeline:

- Stage 1 compares the code with the knee points, picks the segment, and captures that segment's parameters.
- Stage 2 multiplies, shifts, adds the base value and saturates.

Top module: `pwl_decompander`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the working control word is all zero, so the block is in pass-through.
- R2: Control word at address 0: bit 0 turns expansion on, bits 7:4 hold the slope shift s, and bits 9:8 select the segment count (0 gives 4 segments, 1 gives 12, 2 gives 16, and 3 is treated as 16).
- R3: Address map: addresses 1 to 8 hold X knee pairs, addresses 9 to 16 hold Y base pairs, and addresses 17 to 32 hold slope K0 to K15 (all 32 bits). In pair word p, bits 15:0 hold point 2p and bits 31:16 hold point 2p+1. An X point keeps only the low 12 bits of its half. X point 0 is always zero, and writes to it are ignored.
- R4: With expansion on, the segment index i is the highest index below the active count N for which X[i] is less than or equal to the code.
- R5: With expansion on, the output is ((K[i] * (code - X[i])) >> s) + Y[i].
- R6: A result above 2^20-1 saturates to 0xFFFFF instead of wrapping.
- R7: With expansion off, out_data equals the input code zero-extended to 20 bits.
- R8: A write becomes visible only from the first frame_start pulse sampled after the write's cycle. Pixels accepted in the cycle of that pulse, or earlier, use the previous curve.
- R9: With out_ready held at 1, a pixel accepted at clock edge k appears on out_valid after edge k+1, and one result can leave every cycle.
- R10: While out_valid is 1 and out_ready is 0, out_data holds steady. No pixel is lost or duplicated, and outputs leave in input order.
- R11: Knee entries at index N or above never take part in the segment choice, even when they hold small values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register word address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse that commits the staged curve |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_code | input | 12 | Compressed pixel code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept a pixel |
| out_data | output | 20 | Linear pixel value |

## Verification
The assertions assume two things about the inputs. First, frame_start is held low between frames, so the working curve can be compared with the staged one. Second, the software keeps X points non-decreasing within the active count, so the chosen knee never lies above the code. The stimulus writes a rising table for the active knees in every curve. It puts deliberately small values only in entries beyond the active count, where R11 says they must be ignored. It pulses frame_start only once a curve is fully written. The random backpressure phase varies both in_valid and out_ready, so that stalls hit every pipeline occupancy.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    localparam int CODE_W_D  = 12;
    localparam int LIN_W_D   = 20;
    localparam int SEG_N_D   = 16;
    localparam int SLOPE_W_D = 32;
    localparam int BASE_W_D  = 16;
    localparam int SHIFT_W_D = 4;
    localparam int ADDR_W_D  = 6;
    localparam int DATA_W_D  = 32;

    // control word field positions
    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_SHIFT_LSB = 4;
    localparam int CTRL_MODE_LSB  = 8;
    localparam int PAIR_HI_LSB    = 16;

    typedef enum logic [1:0] {
        SEGS_4    = 2'd0,
        SEGS_12   = 2'd1,
        SEGS_16   = 2'd2,
        SEGS_RSVD = 2'd3
    } seg_mode_e;

    typedef enum logic {
        CFG_SYNCED = 1'b0,
        CFG_STAGED = 1'b1
    } cfg_state_e;

    function automatic int unsigned seg_span(seg_mode_e m, int unsigned cap);
        int unsigned n;
        case (m)
            SEGS_4:  n = 4;
            SEGS_12: n = 12;
            default: n = 16;
        endcase
        return (n > cap) ? cap : n;
    endfunction

endpackage

// File: rtl/pwl_cfg_regs.sv
module pwl_cfg_regs
    import pwl_pkg::*;
#(
    parameter int CODE_W  = CODE_W_D,
    parameter int SLOPE_W = SLOPE_W_D,
    parameter int BASE_W  = BASE_W_D,
    parameter int SHIFT_W = SHIFT_W_D,
    parameter int SEG_N   = SEG_N_D,
    parameter int ADDR_W  = ADDR_W_D,
    parameter int DATA_W  = DATA_W_D
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            frame_start,
    output logic                            act_en,
    output logic [SHIFT_W-1:0]              act_shift,
    output seg_mode_e                       act_mode,
    output logic [SEG_N-1:0][CODE_W-1:0]    act_x,
    output logic [SEG_N-1:0][BASE_W-1:0]    act_y,
    output logic [SEG_N-1:0][SLOPE_W-1:0]   act_k
);

    localparam int PAIRS  = SEG_N / 2;
    localparam int X_BASE = 1;
    localparam int Y_BASE = X_BASE + PAIRS;
    localparam int K_BASE = Y_BASE + PAIRS;

    logic                            stg_en;
    logic [SHIFT_W-1:0]              stg_shift;
    seg_mode_e                       stg_mode;
    logic [SEG_N-1:0][CODE_W-1:0]    stg_x;
    logic [SEG_N-1:0][BASE_W-1:0]    stg_y;
    logic [SEG_N-1:0][SLOPE_W-1:0]   stg_k;

    cfg_state_e state_q, state_d;
    logic       commit;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // staging copy, written by the register port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_en    <= 1'b0;
            stg_shift <= '0;
            stg_mode  <= SEGS_4;
            stg_x     <= '0;
            stg_y     <= '0;
            stg_k     <= '0;
        end else if (wr_en) begin
            if (wr_addr == '0) begin
                stg_en    <= wr_data[CTRL_EN_BIT];
                stg_shift <= wr_data[CTRL_SHIFT_LSB +: SHIFT_W];
                stg_mode  <= seg_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
            end
            for (int p = 0; p < PAIRS; p++) begin
                if (wr_addr == ADDR_W'(X_BASE + p)) begin
                    if (p != 0) begin
                        stg_x[2*p] <= wr_data[CODE_W-1:0];
                    end
                    stg_x[2*p+1] <= wr_data[PAIR_HI_LSB +: CODE_W];
                end
                if (wr_addr == ADDR_W'(Y_BASE + p)) begin
                    stg_y[2*p]   <= wr_data[BASE_W-1:0];
                    stg_y[2*p+1] <= wr_data[PAIR_HI_LSB +: BASE_W];
                end
            end
            for (int s = 0; s < SEG_N; s++) begin
                if (wr_addr == ADDR_W'(K_BASE + s)) begin
                    stg_k[s] <= wr_data[SLOPE_W-1:0];
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_SYNCED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_SYNCED: if (wr_en) state_d = CFG_STAGED;
            CFG_STAGED: if (frame_start && !wr_en) state_d = CFG_SYNCED;
            default:    state_d = CFG_SYNCED;
        endcase
    end

    assign commit = frame_start && (state_q == CFG_STAGED);

    // outputs: working curve
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_en    <= 1'b0;
            act_shift <= '0;
            act_mode  <= SEGS_4;
            act_x     <= '0;
            act_y     <= '0;
            act_k     <= '0;
        end else if (commit) begin
            act_en    <= stg_en;
            act_shift <= stg_shift;
            act_mode  <= stg_mode;
            act_x     <= stg_x;
            act_y     <= stg_y;
            act_k     <= stg_k;
        end
    end

    // R8
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_k) && $stable(act_x) && $stable(act_y)
                          && $stable(act_en) && $stable(act_shift)));

    // R8
    synced_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_SYNCED) |-> (stg_x == act_x && stg_y == act_y
                                     && stg_k == act_k && stg_en == act_en));

endmodule

// File: rtl/pwl_seg_select.sv
module pwl_seg_select
    import pwl_pkg::*;
#(
    parameter int CODE_W  = CODE_W_D,
    parameter int SLOPE_W = SLOPE_W_D,
    parameter int BASE_W  = BASE_W_D,
    parameter int SHIFT_W = SHIFT_W_D,
    parameter int SEG_N   = SEG_N_D
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic                            in_valid,
    input  logic [CODE_W-1:0]               in_code,
    input  logic                            cfg_en,
    input  logic [SHIFT_W-1:0]              cfg_shift,
    input  seg_mode_e                       cfg_mode,
    input  logic [SEG_N-1:0][CODE_W-1:0]    cfg_x,
    input  logic [SEG_N-1:0][BASE_W-1:0]    cfg_y,
    input  logic [SEG_N-1:0][SLOPE_W-1:0]   cfg_k,
    output logic                            s1_valid,
    output logic                            s1_en,
    output logic [SHIFT_W-1:0]              s1_shift,
    output logic [CODE_W-1:0]               s1_off,
    output logic [SLOPE_W-1:0]              s1_slope,
    output logic [BASE_W-1:0]               s1_base,
    output logic [CODE_W-1:0]               s1_raw
);

    localparam int SEL_W = $clog2(SEG_N);

    logic [SEL_W-1:0] sel;
    int unsigned      nseg;

    assign nseg = seg_span(cfg_mode, SEG_N);

    // highest active knee at or below the code
    always_comb begin
        sel = '0;
        for (int i = 1; i < SEG_N; i++) begin
            if ((i < int'(nseg)) && (cfg_x[i] <= in_code)) begin
                sel = SEL_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_en    <= 1'b0;
            s1_shift <= '0;
            s1_off   <= '0;
            s1_slope <= '0;
            s1_base  <= '0;
            s1_raw   <= '0;
        end else if (load) begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_en    <= cfg_en;
                s1_shift <= cfg_shift;
                s1_off   <= in_code - cfg_x[sel];
                s1_slope <= cfg_k[sel];
                s1_base  <= cfg_y[sel];
                s1_raw   <= in_code;
            end
        end
    end

    // R4
    knee_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (cfg_x[sel] <= in_code));

endmodule

// File: rtl/pwl_expand.sv
module pwl_expand
    import pwl_pkg::*;
#(
    parameter int CODE_W  = CODE_W_D,
    parameter int LIN_W   = LIN_W_D,
    parameter int SLOPE_W = SLOPE_W_D,
    parameter int BASE_W  = BASE_W_D,
    parameter int SHIFT_W = SHIFT_W_D
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 s1_valid,
    input  logic                 s1_en,
    input  logic [SHIFT_W-1:0]   s1_shift,
    input  logic [CODE_W-1:0]    s1_off,
    input  logic [SLOPE_W-1:0]   s1_slope,
    input  logic [BASE_W-1:0]    s1_base,
    input  logic [CODE_W-1:0]    s1_raw,
    output logic                 out_valid,
    output logic [LIN_W-1:0]     out_data
);

    localparam int PROD_W = SLOPE_W + CODE_W;
    localparam int SUM_W  = PROD_W + 1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [SUM_W-1:0]  sum;
    logic [LIN_W-1:0]  lin;
    logic [LIN_W-1:0]  result;

    always_comb begin
        prod   = PROD_W'(s1_slope) * PROD_W'(s1_off);
        scaled = prod >> s1_shift;
        sum    = SUM_W'(scaled) + SUM_W'(s1_base);
        lin    = (sum > SUM_W'({LIN_W{1'b1}})) ? {LIN_W{1'b1}} : sum[LIN_W-1:0];
        result = s1_en ? lin : LIN_W'(s1_raw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= result;
            end
        end
    end

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && s1_valid && !s1_en) |=> (out_data == LIN_W'($past(s1_raw))));

    // R5
    base_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && s1_valid && s1_en) |=> (out_data >= LIN_W'($past(s1_base))));

endmodule

// File: rtl/pwl_decompander.sv
module pwl_decompander
    import pwl_pkg::*;
#(
    parameter int CODE_W  = CODE_W_D,
    parameter int LIN_W   = LIN_W_D,
    parameter int SEG_N   = SEG_N_D,
    parameter int SLOPE_W = SLOPE_W_D,
    parameter int BASE_W  = BASE_W_D,
    parameter int SHIFT_W = SHIFT_W_D,
    parameter int ADDR_W  = ADDR_W_D,
    parameter int DATA_W  = DATA_W_D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               frame_start,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CODE_W-1:0]  in_code,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LIN_W-1:0]   out_data
);

    logic                            act_en;
    logic [SHIFT_W-1:0]              act_shift;
    seg_mode_e                       act_mode;
    logic [SEG_N-1:0][CODE_W-1:0]    act_x;
    logic [SEG_N-1:0][BASE_W-1:0]    act_y;
    logic [SEG_N-1:0][SLOPE_W-1:0]   act_k;

    logic                 s1_valid, s1_en;
    logic [SHIFT_W-1:0]   s1_shift;
    logic [CODE_W-1:0]    s1_off, s1_raw;
    logic [SLOPE_W-1:0]   s1_slope;
    logic [BASE_W-1:0]    s1_base;

    logic s1_load, s2_load;

    assign s2_load  = out_ready || !out_valid;
    assign s1_load  = s2_load || !s1_valid;
    assign in_ready = s1_load;

    pwl_cfg_regs #(
        .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .BASE_W(BASE_W),
        .SHIFT_W(SHIFT_W), .SEG_N(SEG_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_start(frame_start),
        .act_en(act_en), .act_shift(act_shift), .act_mode(act_mode),
        .act_x(act_x), .act_y(act_y), .act_k(act_k)
    );

    pwl_seg_select #(
        .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .BASE_W(BASE_W),
        .SHIFT_W(SHIFT_W), .SEG_N(SEG_N)
    ) i_sel (
        .clk(clk), .rst_n(rst_n), .load(s1_load),
        .in_valid(in_valid), .in_code(in_code),
        .cfg_en(act_en), .cfg_shift(act_shift), .cfg_mode(act_mode),
        .cfg_x(act_x), .cfg_y(act_y), .cfg_k(act_k),
        .s1_valid(s1_valid), .s1_en(s1_en), .s1_shift(s1_shift),
        .s1_off(s1_off), .s1_slope(s1_slope), .s1_base(s1_base),
        .s1_raw(s1_raw)
    );

    pwl_expand #(
        .CODE_W(CODE_W), .LIN_W(LIN_W), .SLOPE_W(SLOPE_W),
        .BASE_W(BASE_W), .SHIFT_W(SHIFT_W)
    ) i_exp (
        .clk(clk), .rst_n(rst_n), .load(s2_load),
        .s1_valid(s1_valid), .s1_en(s1_en), .s1_shift(s1_shift),
        .s1_off(s1_off), .s1_slope(s1_slope), .s1_base(s1_base),
        .s1_raw(s1_raw),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/test_pwl_decompander.sv
`timescale 1ns/100ps
module test_pwl_decompander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_code = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [19:0] out_data;

    always #2 clk = ~clk;

    pwl_decompander i_pwl_decompander (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    rnd_ready = 1'b0;
    bit    done = 1'b0;

    // reference state: staged and working copies
    bit          s_en, a_en;
    int unsigned s_shift, a_shift, s_mode, a_mode;
    int unsigned s_x[16], a_x[16], s_y[16], a_y[16];
    longint unsigned s_k[16], a_k[16];
    int unsigned exp_q[$];

    // curve under construction by the test
    int unsigned cx[16], cy[16];
    longint unsigned ck[16];

    function automatic int unsigned model_px(int unsigned code);
        int unsigned n, idx;
        longint unsigned v;
        if (!a_en) return code;
        n = (a_mode == 0) ? 4 : (a_mode == 1) ? 12 : 16;
        idx = 0;
        for (int i = 1; i < n; i++) if (a_x[i] <= code) idx = i;
        v = a_k[idx] * longint'(code - a_x[idx]);
        v = v >> a_shift;
        v = v + a_y[idx];
        if (v > 64'hFFFFF) v = 64'hFFFFF;
        return int'(v);
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor, sampled shortly before each rising edge
    bit          prev_stall = 1'b0;
    logic [19:0] prev_data = '0;
    always begin
        @(negedge clk);
        #1.5;
        if (rst_n) begin
            if (prev_stall) check({cur_req, " R10 hold"}, {out_valid, out_data}, {1'b1, prev_data});
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check({cur_req, " R10 extra output"}, 1, 0);
                else check(cur_req, out_data, exp_q.pop_front());
            end
            if (in_valid && in_ready) exp_q.push_back(model_px(in_code));
            if (frame_start) begin
                a_en = s_en; a_shift = s_shift; a_mode = s_mode;
                a_x = s_x; a_y = s_y; a_k = s_k;
            end
            if (wr_en) begin
                if (wr_addr == 0) begin
                    s_en = wr_data[0]; s_shift = wr_data[7:4]; s_mode = wr_data[9:8];
                end else if (wr_addr <= 8) begin
                    if (wr_addr != 1) s_x[2*(wr_addr-1)] = wr_data[11:0];
                    s_x[2*(wr_addr-1)+1] = wr_data[27:16];
                end else if (wr_addr <= 16) begin
                    s_y[2*(wr_addr-9)] = wr_data[15:0];
                    s_y[2*(wr_addr-9)+1] = wr_data[31:16];
                end else if (wr_addr <= 32) begin
                    s_k[wr_addr-17] = wr_data;
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    always @(negedge clk) out_ready = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;

    task automatic write_reg(int unsigned addr, int unsigned data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send(int unsigned code);
        bit got;
        @(negedge clk);
        in_valid = 1'b1; in_code = 12'(code);
        do begin
            #1;
            got = in_ready;
            @(negedge clk);
        end while (!got);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
        check({cur_req, " drain"}, exp_q.size(), 0);
    endtask

    task automatic program_curve(int unsigned ctrl, int unsigned x0_low);
        for (int p = 0; p < 8; p++) begin
            int unsigned lo;
            lo = (p == 0) ? x0_low : cx[2*p];
            write_reg(1 + p, (cx[2*p+1] << 16) | lo);
            write_reg(9 + p, (cy[2*p+1] << 16) | cy[2*p]);
        end
        for (int s = 0; s < 16; s++) write_reg(17 + s, int'(ck[s]));
        write_reg(0, ctrl);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 in_ready", in_ready, 1);

        // R7 pass-through after reset
        cur_req = "R7 bypass";
        send(0); send(12'hABC); send(12'hFFF); send(1);
        drain();

        // R9 latency: accept at edge k, valid after k+1
        cur_req = "R9 latency";
        @(negedge clk);
        in_valid = 1'b1; in_code = 12'h123;
        @(negedge clk);
        in_valid = 1'b0;
        #1.5;
        check("R9 not yet valid", out_valid, 0);
        @(negedge clk);
        #1.5;
        check("R9 valid after two edges", out_valid, 1);
        drain();

        // curve A: 4 segments, shift 2, entries past 4 small (R11), X0 write ignored (R3)
        for (int i = 0; i < 16; i++) begin
            cx[i] = (i < 4) ? ((i == 0) ? 0 : (i == 1) ? 256 : (i == 2) ? 1024 : 2048) : 10;
            cy[i] = (i < 4) ? i * 1500 : 7;
            ck[i] = (i < 4) ? (4 << (2 * i)) : 1;
        end
        program_curve(32'h0000_0021, 12'h123);
        cur_req = "R8 before commit";
        send(100); send(3000);
        drain();
        pulse_frame();
        cur_req = "R4 R5 R11 curve A";
        foreach (cx[i]) if (i < 1) ; // keep loop form simple
        send(0); send(5); send(100); send(255); send(256); send(257);
        send(1023); send(1024); send(2047); send(2048); send(4095);
        drain();

        // curve B: 12 segments, shift 0, entries 12..15 small (R11)
        for (int i = 0; i < 16; i++) begin
            cx[i] = (i < 12) ? i * 300 : 50;
            cy[i] = (i < 12) ? i * 1000 : 3;
            ck[i] = (i < 12) ? i + 1 : 9;
        end
        program_curve(32'h0000_0101, 0);
        pulse_frame();
        cur_req = "R2 R4 R11 curve B";
        for (int c = 0; c < 4096; c += 173) send(c);
        send(3300); send(3299); send(4095); send(60);
        drain();

        // curve C: 16 segments, shift 15, steep tail saturates (R6)
        for (int i = 0; i < 16; i++) begin
            cx[i] = i * 256;
            cy[i] = i * 4000;
            ck[i] = (i == 15) ? 64'hFFFF_FFFF : 64'(32768 * (i + 1));
        end
        program_curve(32'h0000_02F1, 0);
        pulse_frame();
        cur_req = "R5 R6 curve C";
        send(3839); send(3840); send(3841); send(4000); send(4095); send(1000);
        drain();

        // R8: write and frame_start in one cycle commit the older staging
        cur_req = "R8 same-cycle";
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd0; wr_data = 32'h0;
        frame_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_start = 1'b0;
        send(4095); send(512);
        drain();
        pulse_frame();
        cur_req = "R7 R8 disabled after commit";
        send(4095); send(512);
        drain();

        // mode 3 acts as 16 segments (R2)
        program_curve(32'h0000_0371, 0);
        pulse_frame();
        cur_req = "R2 mode 3";
        send(3900); send(4095); send(700);
        drain();

        // random stream with backpressure (R10)
        cur_req = "R10 backpressure";
        rnd_ready = 1'b1;
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) @(negedge clk);
            send($urandom_range(0, 4095));
        end
        for (int t = 0; t < 400 && exp_q.size() != 0; t++) @(negedge clk);
        rnd_ready = 1'b0;
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule